// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block sits on the host side of a serial sampling converter. It brings the converter up and then fetches one result for each request. One output line, the conversion strobe, does two jobs: it starts conversions and it frames the converter's serial port. The serial side is a full-duplex 16-bit master that drives the clock, sends data out and samples data in, most significant bit first.

The first request after reset runs a configure sequence, in this order:
1. Pulse the strobe to open the port.
2. Send the configuration word. The word read back during this frame is meaningless and is dropped.
3. Wait a timed power-up interval.

Every request, including the first, then runs a conversion:
1. Pulse the strobe.
2. Wait the conversion time, measured from the strobe's falling edge.
3. Run a read frame that sends the control word again. The 10-bit code sits left-justified in the 16 bits returned.

The strobe's resting level selects the converter's operating mode. A high rest keeps the converter awake. A low rest lets it power down between conversions. The level is taken from an input at each request.

Top module: `adc_seq_host`

## Requirements
- R1: While reset is held and just after it, `busy` and `res_valid` are 0, `spi_sclk` is low and `cnv_n` is high.
- R2: Each serial frame has exactly 16 rising clock edges. `spi_mosi` carries the word MSB first, stable at each rising edge. `spi_miso` is sampled on the rising edges.
- R3: The first request after reset sends `cfg_word` in a frame before the conversion frame. That frame's read data never appears on `res_code`, and exactly one `res_valid` pulse is produced for the request.
- R4: After the configure frame's last clock, at least `PWRUP_CYC` clock cycles pass before the strobe next changes.
- R5: The first serial clock rise of a read frame comes at least `CONV_CYC` cycles after the strobe's falling edge. In awake mode that falling edge is the start of the pulse; in power-down mode it is the end of the pulse.
- R6: `res_code` equals bits 15 to 6 of the word returned in the read frame; bits 5 to 0 are ignored. `res_valid` is high for exactly one cycle, in the cycle after the frame's last clock.
- R7: `busy` is high from the cycle after an accepted `start` until `res_valid`, and low in the cycle `res_valid` is high.
- R8: Later requests skip the configure sequence. Each of them produces exactly one frame, carrying `ctrl_word`.
- R9: When idle, `cnv_n` rests at the level of `keep_awake` (1 = high rest, 0 = low rest). Each pulse drives it to the opposite level.
- R10: `start` while busy is ignored. `cfg_word`, `ctrl_word` and `keep_awake` are captured when a request is accepted, so changing them during a run has no effect on it.
- R11: `cnv_n` does not change while a frame is in progress, and `spi_sclk` is low outside frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion (ignored while busy) |
| keep_awake | input | 1 | Strobe rest level: 1 high (converter stays awake), 0 low (power-down between conversions) |
| cfg_word | input | 16 | Word sent in the configure frame |
| ctrl_word | input | 16 | Word sent in each read frame |
| spi_miso | input | 1 | Serial data from the converter |
| cnv_n | output | 1 | Conversion-start and port-framing strobe |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | A request is in progress |
| res_code | output | 10 | Latest conversion code |
| res_valid | output | 1 | One-cycle pulse when `res_code` is updated |

## Verification
A converter stub in the bench records every frame and timestamps each strobe edge and serial clock edge. Comparing the stub's captured words against `cfg_word` and `ctrl_word` separates a configure run from a plain run. It also shows whether MSB-first shifting is correct.

The returned codes are chosen to tell apart a correct result from specific faults:
- all-ones and all-zeros codes catch stuck bits;
- a mixed pattern catches a one-bit slip in the result slice;
- nonzero bits below the code catch leakage of the ignored low bits;
- a distinct garbage word in the configure frame catches a leaked configure read.

Both rest levels are exercised, because they place the falling edge that starts the conversion timing at opposite ends of the pulse. A run that pokes `start` and changes the words mid-flight checks that captured values hold.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CFG_PULSE,
        S_CFG_FRAME,
        S_PWR_WAIT,
        S_CNV_PULSE,
        S_CNV_WAIT,
        S_RD_FRAME
    } seq_state_e;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = value;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_spi_xfer.sv
module adc_spi_xfer #(
    parameter int unsigned W    = 16,
    parameter int unsigned HALF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] tx,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic [W-1:0] rx,
    output logic         done,
    output logic         active
);
    localparam int unsigned DIV_W = $clog2(HALF + 1);
    localparam int unsigned BIT_W = $clog2(W);

    typedef struct packed {
        logic             act;
        logic             sclk;
        logic             done;
        logic [DIV_W-1:0] cnt;
        logic [BIT_W-1:0] bitc;
        logic [W-1:0]     sh;
        logic [W-1:0]     rx;
    } spi_r_t;

    spi_r_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.act) begin
            if (go) begin
                r_d.act  = 1'b1;
                r_d.sclk = 1'b0;
                r_d.cnt  = '0;
                r_d.bitc = '0;
                r_d.sh   = tx;
            end
        end else if (r_q.cnt == DIV_W'(HALF - 1)) begin
            r_d.cnt  = '0;
            r_d.sclk = !r_q.sclk;
            if (!r_q.sclk) begin
                r_d.rx = {r_q.rx[W-2:0], miso};
            end else if (r_q.bitc == BIT_W'(W - 1)) begin
                r_d.act  = 1'b0;
                r_d.done = 1'b1;
            end else begin
                r_d.bitc = r_q.bitc + 1'b1;
                r_d.sh   = {r_q.sh[W-2:0], 1'b0};
            end
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sclk   = r_q.sclk;
    assign mosi   = r_q.sh[W-1];
    assign rx     = r_q.rx;
    assign done   = r_q.done;
    assign active = r_q.act;

    // R11: serial clock rests low outside a frame
    assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk);

    // R2: mosi only changes on a falling serial edge or at frame start
    assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$fell(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int unsigned FRAME_W   = 16,
    parameter int unsigned CODE_W    = 10,
    parameter int unsigned SCLK_HALF = 2,
    parameter int unsigned PULSE_CYC = 4,
    parameter int unsigned PWRUP_CYC = 150,
    parameter int unsigned CONV_CYC  = 230
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              keep_awake,
    input  logic [FRAME_W-1:0] cfg_word,
    input  logic [FRAME_W-1:0] ctrl_word,
    input  logic              spi_miso,
    output logic              cnv_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              busy,
    output logic [CODE_W-1:0] res_code,
    output logic              res_valid
);
    localparam int unsigned TMR_W = $clog2(PWRUP_CYC + CONV_CYC + PULSE_CYC + 1);

    typedef struct packed {
        seq_state_e         st;
        logic               conv;
        logic               go;
        logic               valid;
        logic               cfg_done;
        logic               mode;
        logic [FRAME_W-1:0] cfg_w;
        logic [FRAME_W-1:0] ctl_w;
        logic [CODE_W-1:0]  res;
    } seq_r_t;

    seq_r_t r_d, r_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [FRAME_W-1:0] spi_tx;
    logic [FRAME_W-1:0] spi_rx;
    logic              spi_done;
    logic              spi_active;

    adc_seq_timer #(.CNT_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .value   (tmr_val),
        .expired (tmr_expired)
    );

    assign spi_tx = (r_q.st == S_CFG_FRAME) ? r_q.cfg_w : r_q.ctl_w;

    adc_spi_xfer #(.W(FRAME_W), .HALF(SCLK_HALF)) u_spi (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (r_q.go),
        .tx     (spi_tx),
        .miso   (spi_miso),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .rx     (spi_rx),
        .done   (spi_done),
        .active (spi_active)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.go    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (r_q.st)
            S_IDLE: begin
                r_d.conv = keep_awake;
                if (start) begin
                    r_d.cfg_w = cfg_word;
                    r_d.ctl_w = ctrl_word;
                    r_d.mode  = keep_awake;
                    r_d.conv  = !keep_awake;
                    r_d.st    = r_q.cfg_done ? S_CNV_PULSE : S_CFG_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(PULSE_CYC - 1);
                end
            end
            S_CFG_PULSE: begin
                if (tmr_expired) begin
                    r_d.conv = r_q.mode;
                    r_d.go   = 1'b1;
                    r_d.st   = S_CFG_FRAME;
                end
            end
            S_CFG_FRAME: begin
                if (spi_done) begin
                    r_d.cfg_done = 1'b1;
                    r_d.st       = S_PWR_WAIT;
                    tmr_load     = 1'b1;
                    tmr_val      = TMR_W'(PWRUP_CYC - 1);
                end
            end
            S_PWR_WAIT: begin
                if (tmr_expired) begin
                    r_d.conv = !r_q.mode;
                    r_d.st   = S_CNV_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PULSE_CYC - 1);
                end
            end
            S_CNV_PULSE: begin
                if (tmr_expired) begin
                    r_d.conv = r_q.mode;
                    r_d.st   = S_CNV_WAIT;
                    tmr_load = 1'b1;
                    // falling edge was at pulse start (high rest) or is now (low rest)
                    tmr_val  = r_q.mode ? TMR_W'(CONV_CYC - PULSE_CYC - 1)
                                        : TMR_W'(CONV_CYC - 1);
                end
            end
            S_CNV_WAIT: begin
                if (tmr_expired) begin
                    r_d.go = 1'b1;
                    r_d.st = S_RD_FRAME;
                end
            end
            S_RD_FRAME: begin
                if (spi_done) begin
                    r_d.res   = spi_rx[FRAME_W-1 -: CODE_W];
                    r_d.valid = 1'b1;
                    r_d.st    = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.conv <= 1'b1;
            r_q.mode <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnv_n     = r_q.conv;
    assign busy      = (r_q.st != S_IDLE);
    assign res_code  = r_q.res;
    assign res_valid = r_q.valid;

    // R6: result strobe lasts one cycle
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R7: busy has dropped when the result is presented
    assert_valid_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy);

    // R8: configure sequence only runs while unconfigured
    assert_cfg_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_CFG_PULSE) |-> !r_q.cfg_done);

    // R11: strobe frozen while the serial engine shifts
    assert_conv_frame_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_active |-> $stable(cnv_n));

    // R3: result only produced from a read frame
    assert_valid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(r_q.st) == S_RD_FRAME));

endmodule

// File: tb/adc_seq_host_bench.sv
module adc_seq_host_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P_HALF  = 2;
    localparam int P_PULSE = 4;
    localparam int P_PWR   = 150;
    localparam int P_CONV  = 230;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        keep_awake = 1'b1;
    logic [15:0] cfg_word = 16'h6040;
    logic [15:0] ctrl_word = 16'h4040;
    logic        spi_miso;
    logic        cnv_n, spi_sclk, spi_mosi, busy, res_valid;
    logic [9:0]  res_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = !clk;

    adc_seq_host #(
        .FRAME_W(16), .CODE_W(10), .SCLK_HALF(P_HALF),
        .PULSE_CYC(P_PULSE), .PWRUP_CYC(P_PWR), .CONV_CYC(P_CONV)
    ) u_adc_seq_host (
        .clk(clk), .rst_n(rst_n), .start(start), .keep_awake(keep_awake),
        .cfg_word(cfg_word), .ctrl_word(ctrl_word), .spi_miso(spi_miso),
        .cnv_n(cnv_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .busy(busy), .res_code(res_code), .res_valid(res_valid)
    );

    // ---------------- converter stub ----------------
    logic [15:0] stub_tx = 16'h0000;
    logic [15:0] stub_rx = 16'h0000;
    logic [15:0] rx_hist [0:15];
    int          bitn = 0;
    int          rises = 0;
    int          frames = 0;
    longint      t_fall = 0, t_frame_end = 0, pwr_gap = 0, conv_gap = 0;
    bit          fresh = 0;

    function automatic longint now_cyc();
        return longint'($time) / CLK_PERIOD;
    endfunction

    assign spi_miso = (bitn < 16) ? stub_tx[15 - bitn] : 1'b0;

    always @(cnv_n) begin
        bitn  = 0;
        rises = 0;
        if (cnv_n === 1'b0) t_fall = now_cyc();
        if (fresh) begin
            pwr_gap = now_cyc() - t_frame_end;
            fresh   = 0;
        end
    end

    always @(posedge spi_sclk) begin
        if (rises == 0) conv_gap = now_cyc() - t_fall;
        rises++;
        stub_rx = {stub_rx[14:0], spi_mosi};
    end

    always @(negedge spi_sclk) begin
        bitn++;
        if (bitn == 16) begin
            if (frames < 16) rx_hist[frames] = stub_rx;
            frames++;
            t_frame_end = now_cyc();
            fresh = 1;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_conv(input logic [9:0] code, input logic [5:0] junk,
                           input bit with_cfg, input bit poke, input string tag);
        int f0 = frames;
        int guard = 0;
        bit drop = 0;
        logic [15:0] exp_cfg = cfg_word;
        logic [15:0] exp_ctl = ctrl_word;
        bit exp_mode = keep_awake;
        stub_tx = with_cfg ? 16'hC3C3 : {code, junk};
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy === 1'b1, "R7", {tag, " busy after start"}, busy, 1);
        while (res_valid !== 1'b1 && guard < 5000) begin
            if (!busy) drop = 1;
            if (with_cfg && frames == f0 + 1) stub_tx = {code, junk};
            if (poke && guard == 50) begin
                start = 1'b1; ctrl_word = 16'h1234; cfg_word = 16'hBEEF;
            end
            if (poke && guard == 51) start = 1'b0;
            @(negedge clk);
            guard++;
        end
        check(!drop, "R7", {tag, " busy held through run"}, drop, 0);
        check(res_valid === 1'b1, "R6", {tag, " valid seen"}, res_valid, 1);
        check(res_code === code, "R6", {tag, " result code"}, res_code, code);
        check(busy === 1'b0, "R7", {tag, " busy low with valid"}, busy, 0);
        check(frames == f0 + (with_cfg ? 2 : 1), with_cfg ? "R3" : "R8",
              {tag, " frame count"}, frames - f0, with_cfg ? 2 : 1);
        if (with_cfg) begin
            check(rx_hist[f0] === exp_cfg, "R2", {tag, " cfg word on mosi"}, rx_hist[f0], exp_cfg);
            check(pwr_gap >= P_PWR, "R4", {tag, " power-up gap"}, pwr_gap, P_PWR);
        end
        check(rx_hist[frames-1] === exp_ctl, "R2", {tag, " ctrl word on mosi"},
              rx_hist[frames-1], exp_ctl);
        check(rises == 16, "R2", {tag, " clock edges in frame"}, rises, 16);
        check(conv_gap >= P_CONV, "R5", {tag, " conversion wait"}, conv_gap, P_CONV);
        @(negedge clk);
        check(res_valid === 1'b0, "R6", {tag, " valid one cycle"}, res_valid, 0);
        check(cnv_n === exp_mode, "R9", {tag, " rest level after run"}, cnv_n, exp_mode);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R1", "busy in reset", busy, 0);
        check(res_valid === 1'b0, "R1", "valid in reset", res_valid, 0);
        check(spi_sclk === 1'b0, "R1", "sclk in reset", spi_sclk, 0);
        check(cnv_n === 1'b1, "R1", "strobe in reset", cnv_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && cnv_n === 1'b1, "R1", "state after reset", {busy, cnv_n}, 1);
    endtask

    task automatic t_first_conv();
        // R3: configure frame precedes conversion, garbage read discarded
        do_conv(10'h2A5, 6'h2B, 1'b1, 1'b0, "first");
    endtask

    task automatic t_repeat_conv();
        // R8: no configure frame, all-ones code with junk low bits (R6)
        do_conv(10'h3FF, 6'h3F, 1'b0, 1'b0, "repeat");
    endtask

    task automatic t_low_rest();
        keep_awake = 1'b0;
        repeat (3) @(negedge clk);
        check(cnv_n === 1'b0, "R9", "low rest level", cnv_n, 0);
        // R5: falling edge at end of pulse in this mode
        do_conv(10'h000, 6'h15, 1'b0, 1'b0, "lowrest");
        keep_awake = 1'b1;
        repeat (3) @(negedge clk);
        check(cnv_n === 1'b1, "R9", "high rest level", cnv_n, 1);
    endtask

    task automatic t_busy_ignore();
        int f0;
        // R10: start and word changes while busy have no effect
        do_conv(10'h155, 6'h01, 1'b0, 1'b1, "poke");
        f0 = frames;
        repeat (400) @(negedge clk);
        check(frames == f0 && busy === 1'b0, "R10", "no extra run from poke", frames - f0, 0);
        ctrl_word = 16'h4040;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_first_conv();
        t_repeat_conv();
        t_low_rest();
        t_busy_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule